// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Memory Burn-and-Check Sequencer

This block is a synchronous controller that writes an image into a byte-wide, UV-erasable, electrically programmable memory and then checks each written byte. A host sets an inclusive address window and pulses a start input. For every address in the window, the sequencer takes one byte from a data source. It reads the location first to confirm that the byte can be written at all. Such memory only lets bits fall from 1 to 0, and only an ultraviolet erase brings them back. If the write is possible, the sequencer raises the high programming supply, drives the byte, fires one timed active-low pulse on chip enable, drops the supply again and reads the location back.

The result for each location appears as a one-cycle strobe with a pass bit. Two sticky flags separate locations that would have needed an erase from locations whose read-back did not match. The address of the first failing location is held. A done level closes the run. The analog switching of the two supplies is left to outside circuitry, which acts on the block's two supply-enable outputs.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset: busy, done, loc_valid, err_erase, err_verify and both supply enables are 0; mem_ce_n and mem_oe_n are 1; mem_drive is 0; fail_addr is 0.
- R2: A start pulse while idle visits the addresses from lo_addr upward in ascending order, ending at hi_addr. If hi_addr is below lo_addr, only lo_addr is visited. Each location takes exactly one byte: src_data is sampled in the single cycle in which src_rd is 1, and mem_addr then holds that location.
- R3: Before the location is written, it is read with mem_ce_n and mem_oe_n at 0 and the program supply off. If a bit is 0 in the stored byte but 1 in the requested byte, the location is reported as failed and err_erase is set. No programming supply and no pulse are applied, so the stored byte is unchanged.
- R4: Each written location gets exactly one pulse: mem_ce_n is 0 for PULSE_CYC consecutive cycles while mem_vpp_on is 1, mem_drive is 1 and mem_dout carries the requested byte. The pulse never exceeds PULSE_MAX_CYC cycles.
- R5: mem_vpp_on is 1 only while mem_vcc_on is 1. mem_vcc_on rises at least SETTLE_CYC cycles before the first rise of mem_vpp_on. It falls at least SETTLE_CYC cycles after the last fall of mem_vpp_on.
- R6: mem_ce_n stays 1 for exactly SETTLE_CYC cycles after mem_vpp_on rises, before the pulse begins. It also stays 1 for exactly SETTLE_CYC cycles after mem_vpp_on falls, before the read-back begins.
- R7: The read-back uses mem_ce_n = 0, mem_oe_n = 0 and the program supply off. loc_valid is then 1 for one cycle while mem_addr still holds the location. In that cycle loc_pass is 1 exactly when the byte read back equals the requested byte.
- R8: err_erase and err_verify stay set until the next accepted start. fail_addr holds the first location in the run that failed for either reason.
- R9: After the last location, mem_vcc_on falls, busy falls and done rises. done stays 1 until the next accepted start, which clears done, both error flags and fail_addr.
- R10: A start pulse while busy is ignored; the run continues over its original window.
- R11: mem_drive is 1 only while mem_vpp_on is 1. mem_oe_n is 0 only while mem_drive and mem_vpp_on are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| lo_addr | input | AW | First address of the window |
| hi_addr | input | AW | Last address of the window |
| src_data | input | DW | Byte offered by the data source |
| src_rd | output | 1 | Byte on src_data consumed this cycle |
| mem_addr | output | AW | Address to the memory |
| mem_dout | output | DW | Byte to drive onto the memory data pins |
| mem_din | input | DW | Byte read from the memory data pins |
| mem_drive | output | 1 | Enable for the data-bus drivers |
| mem_ce_n | output | 1 | Chip enable / programming pulse, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_vpp_on | output | 1 | Switch the high programming supply on |
| mem_vcc_on | output | 1 | Switch the main supply on |
| busy | output | 1 | Run in progress |
| loc_valid | output | 1 | One-cycle result strobe for the location on mem_addr |
| loc_pass | output | 1 | Location written and read back correctly |
| err_erase | output | 1 | Sticky: a location needed a 0-to-1 change |
| err_verify | output | 1 | Sticky: a read-back mismatched |
| fail_addr | output | AW | First failing location of the run |
| done | output | 1 | Run finished |

## Verification
The bench models the memory itself: writes can only clear bits, and some cells are stuck at 1. This lets it create both an impossible rewrite and a read-back mismatch. A sequencer that skipped the pre-read would pulse a location that cannot take the data, so the stored byte would change. A sequencer that compared the wrong way round would pass a stuck cell. Pulse length and both settle gaps are measured on the pins: an off-by-one counter shows up as a pulse of PULSE_CYC±1 or a gap of SETTLE_CYC±1. The bench also runs a reversed window, a start during a run, and a run after a failing one. These catch a counter that wraps through the whole address space, a run restarted mid-way, and flags or a fail address carried over from the previous run.

// File: rtl/prom_burn_seq.sv
module prom_burn_seq #(
  parameter int AW            = 12,
  parameter int DW            = 8,
  parameter int SETTLE_CYC    = 400,
  parameter int PULSE_CYC     = 10_000_000,
  parameter int PULSE_MAX_CYC = 11_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic [DW-1:0] src_data,
  output logic          src_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  input  logic [DW-1:0] mem_din,
  output logic          mem_drive,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_vpp_on,
  output logic          mem_vcc_on,
  output logic          busy,
  output logic          loc_valid,
  output logic          loc_pass,
  output logic          err_erase,
  output logic          err_verify,
  output logic [AW-1:0] fail_addr,
  output logic          done
);

  localparam int CMAX = (SETTLE_CYC > PULSE_MAX_CYC) ? SETTLE_CYC : PULSE_MAX_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SETL = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] PUL  = CW'(PULSE_CYC - 1);
  localparam logic [CW:0]   PMAX = (CW+1)'(PULSE_MAX_CYC);

  typedef enum logic [3:0] {
    S_IDLE, S_PWRUP, S_FETCH, S_PRE, S_RAMP, S_PULSE, S_FALL, S_VER, S_NEXT, S_PWRDN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr, last;
  logic [DW-1:0] wdat;
  logic          tick, any_fail;

  assign tick       = (cnt == '0);
  assign any_fail   = err_erase | err_verify;
  assign busy       = (st != S_IDLE);
  assign mem_vcc_on = busy;
  assign mem_vpp_on = (st == S_RAMP) || (st == S_PULSE);
  assign mem_drive  = mem_vpp_on;
  assign mem_ce_n   = !((st == S_PRE) || (st == S_PULSE) || (st == S_VER));
  assign mem_oe_n   = !((st == S_PRE) || (st == S_VER));
  assign src_rd     = (st == S_FETCH);
  assign mem_addr   = addr;
  assign mem_dout   = wdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  addr <= '0;  last <= '0;  wdat <= '0;
      done <= 1'b0;  err_erase <= 1'b0;  err_verify <= 1'b0;  fail_addr <= '0;
      loc_valid <= 1'b0;  loc_pass <= 1'b0;
    end else begin
      loc_valid <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          addr <= lo_addr;  last <= hi_addr;  done <= 1'b0;
          err_erase <= 1'b0;  err_verify <= 1'b0;  fail_addr <= '0;
          st <= S_PWRUP;  cnt <= SETL;
        end
        S_PWRUP: if (tick) st <= S_FETCH;
        S_FETCH: begin
          wdat <= src_data;  st <= S_PRE;  cnt <= SETL;
        end
        S_PRE: if (tick) begin
          if (|(~mem_din & wdat)) begin
            err_erase <= 1'b1;  loc_valid <= 1'b1;  loc_pass <= 1'b0;
            if (!any_fail) fail_addr <= addr;
            st <= S_NEXT;
          end else begin
            st <= S_RAMP;  cnt <= SETL;
          end
        end
        S_RAMP:  if (tick) begin st <= S_PULSE; cnt <= PUL;  end
        S_PULSE: if (tick) begin st <= S_FALL;  cnt <= SETL; end
        S_FALL:  if (tick) begin st <= S_VER;   cnt <= SETL; end
        S_VER: if (tick) begin
          loc_valid <= 1'b1;
          loc_pass  <= (mem_din == wdat);
          if (mem_din != wdat) begin
            err_verify <= 1'b1;
            if (!any_fail) fail_addr <= addr;
          end
          st <= S_NEXT;
        end
        S_NEXT: if (addr >= last) begin
          st <= S_PWRDN;  cnt <= SETL;
        end else begin
          addr <= addr + 1'b1;  st <= S_FETCH;
        end
        S_PWRDN: if (tick) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] pw;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pw <= '0;
    else        pw <= (mem_vpp_on && !mem_ce_n) ? pw + 1'b1 : '0;

  a_r4_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pw <= PMAX);
  a_r5_supply_order: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vpp_on |-> mem_vcc_on);
  a_r6_supply_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && mem_vpp_on) |-> $past(mem_vpp_on));
  a_r11_bus_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_drive && !mem_vpp_on));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_verify_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_verify) |=> err_verify);

endmodule

// File: tb/tb_prom_burn_seq.sv
module tb_prom_burn_seq;
  localparam int AW = 8, DW = 8, ST = 3, PU = 5, PM = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] lo_addr = 0, hi_addr = 0, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_dout, mem_din;
  logic src_rd, mem_drive, mem_ce_n, mem_oe_n, mem_vpp_on, mem_vcc_on;
  logic busy, loc_valid, loc_pass, err_erase, err_verify, done;

  always #2.5 clk = ~clk;

  prom_burn_seq #(.AW(AW), .DW(DW), .SETTLE_CYC(ST), .PULSE_CYC(PU), .PULSE_MAX_CYC(PM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lo_addr(lo_addr), .hi_addr(hi_addr),
    .src_data(src_data), .src_rd(src_rd), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_drive(mem_drive), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_vpp_on(mem_vpp_on), .mem_vcc_on(mem_vcc_on), .busy(busy), .loc_valid(loc_valid),
    .loc_pass(loc_pass), .err_erase(err_erase), .err_verify(err_verify),
    .fail_addr(fail_addr), .done(done));

  // memory model: bits only clear, stuck cells stay 1
  logic [7:0] mem   [256];
  logic [7:0] stuck [256];
  logic [7:0] img   [64];
  int rp = 0;
  assign src_data = img[rp[5:0]];
  assign mem_din  = (!mem_ce_n && !mem_oe_n && !mem_vpp_on) ? mem[mem_addr] : 8'h00;

  always @(posedge clk) begin
    if (src_rd) rp <= rp + 1;
    if (mem_vpp_on && !mem_ce_n && mem_drive)
      mem[mem_addr] <= mem[mem_addr] & (mem_dout | stuck[mem_addr]);
  end

  int n_chk = 0, n_err = 0, cyc = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R9 watchdog: actual busy expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // reference model state
  bit mon = 0;
  int exp_addr, locs;
  logic [7:0] p_addr, p_data, p_after;
  bit p_pass, x_ee, x_ev, x_any;
  logic [7:0] x_fa;
  logic q_vcc = 0, q_vpp = 0, q_ce = 1;
  int vcc_age = 0, off_age = 0, ramp_n = 0, pl_n = 0, gap_n = 0;
  bit gap_arm = 0, pl_ok = 1;

  always @(negedge clk) if (mon) begin
    chk(!(mem_vpp_on && !mem_vcc_on), "R5", "vpp without vcc", mem_vpp_on, 0);
    if (mem_drive || !mem_oe_n)
      chk(!(mem_drive && !mem_vpp_on) && !(!mem_oe_n && (mem_drive || mem_vpp_on)),
          "R11", "bus drive conflict", {mem_drive, mem_oe_n, mem_vpp_on}, 3'b010);
    if (mem_vpp_on && !q_vpp) chk(vcc_age >= ST, "R5", "vcc lead", vcc_age, ST);
    if (!mem_vcc_on && q_vcc) chk(off_age >= ST, "R5", "vcc trail", off_age, ST);
    if (!mem_ce_n && q_ce && mem_vpp_on) chk(ramp_n == ST, "R6", "settle before pulse", ramp_n, ST);
    if (!mem_ce_n && q_ce && !mem_vpp_on && gap_arm) begin
      chk(gap_n == ST, "R6", "settle before read-back", gap_n, ST);
      gap_arm = 0;
    end
    if (!(mem_vpp_on && !mem_ce_n) && pl_n > 0) begin
      chk(pl_n == PU && pl_ok, "R4", "pulse width/data", pl_n, PU);
      pl_n = 0; pl_ok = 1; gap_arm = 1;
    end
    if (src_rd) begin
      chk(mem_addr == exp_addr[7:0], "R2", "visit order", mem_addr, exp_addr);
      p_addr = mem_addr; p_data = src_data;
      if ((~mem[mem_addr] & src_data) != 0) begin
        p_pass = 0; p_after = mem[mem_addr];
      end else begin
        p_after = mem[mem_addr] & (src_data | stuck[mem_addr]);
        p_pass = (p_after == src_data);
      end
      exp_addr++;
    end
    if (loc_valid) begin
      locs++;
      chk(mem_addr == p_addr, "R7", "result address", mem_addr, p_addr);
      chk(loc_pass == p_pass, "R7", "pass bit", loc_pass, p_pass);
      chk(mem[mem_addr] == p_after, "R3", "stored byte", mem[mem_addr], p_after);
      if (!p_pass) begin
        if ((~p_after & p_data) != 0 && p_after == mem[mem_addr] && (~p_after & p_data & ~stuck[p_addr]) != 0) x_ee = 1;
        else x_ev = 1;
        if (!x_any) x_fa = p_addr;
        x_any = 1;
      end
    end
    if (mem_vpp_on && !mem_ce_n) begin
      pl_n++; pl_ok &= mem_drive && (mem_dout == p_data);
    end
    ramp_n  = (mem_vpp_on && mem_ce_n) ? ramp_n + 1 : (mem_vpp_on ? ramp_n : 0);
    gap_n   = mem_vpp_on ? 0 : ((mem_vcc_on && mem_ce_n) ? gap_n + 1 : gap_n);
    vcc_age = mem_vcc_on ? vcc_age + 1 : 0;
    off_age = (!mem_vcc_on || mem_vpp_on) ? 0 : off_age + 1;
    q_vcc = mem_vcc_on; q_vpp = mem_vpp_on; q_ce = mem_ce_n;
  end

  task automatic pulse_start(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); lo_addr = lo; hi_addr = hi; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(input logic [7:0] lo, input logic [7:0] hi, input int n,
                     input bit ee, input bit ev, input logic [7:0] fa);
    @(negedge clk);
    rp = 0; exp_addr = lo; locs = 0; x_ee = 0; x_ev = 0; x_any = 0; x_fa = 0;
    pulse_start(lo, hi);
    chk(!done && err_erase == 0 && err_verify == 0, "R9", "flags cleared on start",
        {done, err_erase, err_verify}, 0);
    while (!done) @(negedge clk);
    chk(!busy && !mem_vcc_on, "R9", "idle at done", {busy, mem_vcc_on}, 0);
    chk(locs == n, "R2", "location count", locs, n);
    chk(err_erase == ee && x_ee == ee, "R3", "erase flag", err_erase, ee);
    chk(err_verify == ev && x_ev == ev, "R8", "verify flag", err_verify, ev);
    chk(fail_addr == fa, "R8", "first fail address", fail_addr, fa);
    repeat (3) @(negedge clk);
    chk(done, "R9", "done held", done, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; stuck[i] = 8'h00; end
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    stuck[20] = 8'h01; stuck[21] = 8'h80;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !loc_valid && !err_erase && !err_verify && fail_addr == 0,
        "R1", "status after reset", {busy, done, loc_valid, err_erase, err_verify}, 0);
    chk(!mem_vcc_on && !mem_vpp_on && mem_ce_n && mem_oe_n && !mem_drive,
        "R1", "pins after reset", {mem_vcc_on, mem_vpp_on, mem_ce_n, mem_oe_n, mem_drive}, 5'b00110);
    rst_n = 1;
    @(negedge clk); mon = 1;

    img[0] = 8'hA5; img[1] = 8'h00; img[2] = 8'hFF; img[3] = 8'h3C;
    run(10, 13, 4, 0, 0, 0);                                  // R2 R4 R7 all pass
    img[0] = 8'hA4; img[1] = 8'h5A;
    run(10, 11, 2, 1, 0, 11);                                 // R3 erase needed at 11
    img[0] = 8'hFE; img[1] = 8'h7F; img[2] = 8'h00;
    run(20, 22, 3, 0, 1, 20);                                 // R8 first verify fail kept
    img[0] = 8'h12;
    run(40, 35, 1, 0, 0, 0);                                  // R2 reversed window
    chk(mem[40] == 8'h12 && mem[35] == 8'hFF, "R2", "reversed window bytes", mem[35], 8'hFF);

    // R10: start during a run is ignored
    img[0] = 8'h11; img[1] = 8'h22; img[2] = 8'h33;
    @(negedge clk);
    rp = 0; exp_addr = 50; locs = 0; x_ee = 0; x_ev = 0; x_any = 0;
    pulse_start(50, 52);
    repeat (20) @(negedge clk);
    pulse_start(0, 0);
    while (!done) @(negedge clk);
    chk(locs == 3, "R10", "count after mid-run start", locs, 3);
    chk(mem[0] == 8'hFF && mem[52] == 8'h33, "R10", "window unchanged", mem[0], 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule